// File: doc/BRIEF.md
# USB Serial Receive Engine

This block turns a recovered USB line bit stream into packet bytes. A strobe qualifies each sampled line level. The selected line rate, full speed or low speed, changes only how often the strobe arrives. While idle, the engine watches for the sync pattern. Once sync is found, it decodes NRZI, discards stuffed bits and shifts the remaining bits, least significant bit first, into bytes.

The first byte of a packet is the packet ID. The engine checks the complement nibble of that byte and uses the ID's two low bits to pick a check. Token packets get a CRC5 check, data packets get a CRC16 check, and handshake or special packets get no CRC check. A separate end-of-packet input closes the packet. At that point the engine publishes the error flags for the whole packet alongside a one-cycle end pulse.

A link-layer controller uses the byte stream and the flags to decide whether to accept a packet. The analog front end, clock recovery, the transmit path and handshake generation all sit outside this block.

Top module: `usb_rx_engine`

## Requirements
- R1: A strobed line level equal to the previous strobed level decodes as 1, and a change decodes as 0. The reference level is 1 (idle) after reset and after every eop_i pulse.
- R2: No byte is produced until, outside a packet, at least SYNC_ZEROS (default 5) decoded zeros are followed by a decoded 1. Strobed bits before that are discarded. eop_i outside a packet produces no pkt_end_o.
- R3: After STUFF_RUN (default 6) consecutive decoded ones, the next decoded bit is dropped and reaches neither the bytes nor the CRC. The closing 1 of sync counts as the first one of a run.
- R4: If a dropped stuff bit is a 1, stuff_err_o is 1 at the end of that packet.
- R5: Kept bits fill bytes least significant bit first. byte_vld_o pulses for one cycle, in the cycle after the strobe of each eighth kept bit. byte_sop_o is 1 only together with the first byte of a packet.
- R6: pid_o takes the low nibble of the first byte. pid_err_o is 1 at packet end when the high nibble is not the one's complement of the low nibble, or when no full byte arrived.
- R7: When the packet ID's bits [1:0] are 01 (token), CRC5 (x^5+x^2+1, all-ones seed) runs over every kept bit after the packet ID. crc_err_o is 1 unless the register ends at the fixed residual of that polynomial.
- R8: When the packet ID's bits [1:0] are 11 (data), the same check uses CRC16 (x^16+x^15+x^2+1, all-ones seed).
- R9: When the packet ID's bits [1:0] are 00 or 10, crc_err_o is 0.
- R10: frame_err_o is 1 at packet end when eop_i arrives with a partly filled byte, or before any byte.
- R11: pkt_end_o pulses for one cycle, in the cycle after eop_i is sampled inside a packet. The four error flags and pid_o change only with pkt_end_o or byte_sop_o respectively, and hold otherwise.
- R12: The decoded bytes and flags do not depend on the spacing between strobes, and the line level is ignored while bit_vld_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_vld_i | input | 1 | Strobe marking a sampled line bit |
| line_i | input | 1 | Sampled line level (1 = idle state) |
| eop_i | input | 1 | End-of-packet pulse |
| byte_o | output | 8 | Received byte |
| byte_vld_o | output | 1 | byte_o valid, one cycle |
| byte_sop_o | output | 1 | Current byte is the packet ID |
| pid_o | output | 4 | Packet ID of the latest packet |
| pkt_end_o | output | 1 | Packet finished, flags valid |
| pid_err_o | output | 1 | Packet ID check failed |
| crc_err_o | output | 1 | CRC residual mismatch |
| stuff_err_o | output | 1 | Stuff bit was a 1 |
| frame_err_o | output | 1 | Packet ended mid-byte |

## Verification
The assertions assume that eop_i is a single-cycle pulse and that a valid byte or packet end can only follow a sampled strobe or end pulse. They also assume that no end pulse is applied while the engine still sits in idle from a previous end. The bench keeps strobes at least four cycles apart and never raises eop_i in the same cycle as bit_vld_i. It returns its NRZI encoder to the idle level after each end pulse, which matches the decoder's reference reset. Stuffing, CRC fields and complement nibbles are generated by an independent transmit model in the bench. Error cases are created by corrupting that model's output.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;
  localparam int unsigned CRC5_W  = 5;
  localparam int unsigned CRC16_W = 16;
  localparam logic [CRC5_W-1:0]  CRC5_POLY  = 5'h05;
  localparam logic [CRC16_W-1:0] CRC16_POLY = 16'h8005;

  typedef enum logic [1:0] {
    PK_SPECIAL   = 2'b00,
    PK_TOKEN     = 2'b01,
    PK_HANDSHAKE = 2'b10,
    PK_DATA      = 2'b11
  } pid_kind_e;

  // Residual left after a register absorbs its own complement, MSB first.
  // Equal to running the all-ones seed over w zeros.
  function automatic logic [15:0] crc_residual(input int unsigned w, input logic [15:0] poly);
    logic [15:0] c;
    logic [15:0] mask;
    logic fb;
    mask = (16'h1 << w) - 16'h1;
    c = mask;
    for (int unsigned i = 0; i < w; i++) begin
      fb = c[w-1];
      c  = ((c << 1) ^ (fb ? poly : 16'h0)) & mask;
    end
    return c;
  endfunction
endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic line_i,
  input  logic idle_i,
  output logic dbit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     prev_q <= 1'b1;
    else if (idle_i) prev_q <= 1'b1;
    else if (stb_i)  prev_q <= line_i;
  end

  assign dbit_o = ~(line_i ^ prev_q);
endmodule

// File: rtl/usb_rx_unstuff.sv
module usb_rx_unstuff #(
  parameter int unsigned RUN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stb_i,
  input  logic bit_i,
  output logic keep_o,
  output logic stuff_err_o
);
  localparam int unsigned OW = $clog2(RUN + 1);
  logic [OW-1:0] ones_q;

  assign keep_o      = (ones_q != OW'(RUN));
  assign stuff_err_o = stb_i && !keep_o && bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ones_q <= '0;
    else if (start_i) ones_q <= OW'(1);
    else if (stb_i) begin
      if (!keep_o)    ones_q <= '0;
      else if (bit_i) ones_q <= ones_q + OW'(1);
      else            ones_q <= '0;
    end
  end
endmodule

// File: rtl/usb_rx_crc.sv
module usb_rx_crc #(
  parameter int unsigned   W    = 5,
  parameter logic [W-1:0] POLY = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_o <= '1;
    else if (clr_i)  crc_o <= '1;
    else if (en_i)   crc_o <= {crc_o[W-2:0], 1'b0} ^ ((crc_o[W-1] ^ bit_i) ? POLY : '0);
  end
endmodule

// File: rtl/usb_rx_engine.sv
module usb_rx_engine
  import usb_rx_pkg::*;
#(
  parameter int unsigned SYNC_ZEROS = 5,
  parameter int unsigned STUFF_RUN  = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_vld_i,
  input  logic       line_i,
  input  logic       eop_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       byte_sop_o,
  output logic [3:0] pid_o,
  output logic       pkt_end_o,
  output logic       pid_err_o,
  output logic       crc_err_o,
  output logic       stuff_err_o,
  output logic       frame_err_o
);
  localparam int unsigned ZW = $clog2(SYNC_ZEROS + 1);
  localparam logic [15:0] RES5_W  = crc_residual(CRC5_W, 16'(CRC5_POLY));
  localparam logic [15:0] RES16_W = crc_residual(CRC16_W, CRC16_POLY);

  logic          in_pkt;
  logic [ZW-1:0] zcnt_q;
  logic [7:0]    sh_q;
  logic [2:0]    bcnt_q;
  logic          first_q, pid_good_q, stuff_acc_q;
  logic          dbit, keep, stuff_hit;
  logic          sync_hit, pkt_stb, keep_stb, crc_bad;
  logic [7:0]    new_byte;
  logic [CRC5_W-1:0]  crc5;
  logic [CRC16_W-1:0] crc16;

  assign sync_hit = !in_pkt && bit_vld_i && !eop_i && dbit && (zcnt_q >= ZW'(SYNC_ZEROS));
  assign pkt_stb  = in_pkt && bit_vld_i && !eop_i;
  assign keep_stb = pkt_stb && keep;
  assign new_byte = {dbit, sh_q[7:1]};

  usb_rx_nrzi u_nrzi (
    .clk_i, .rst_ni, .stb_i(bit_vld_i), .line_i, .idle_i(eop_i), .dbit_o(dbit)
  );

  usb_rx_unstuff #(.RUN(STUFF_RUN)) u_unstuff (
    .clk_i, .rst_ni, .start_i(sync_hit), .stb_i(pkt_stb), .bit_i(dbit),
    .keep_o(keep), .stuff_err_o(stuff_hit)
  );

  usb_rx_crc #(.W(CRC5_W), .POLY(CRC5_POLY)) u_crc5 (
    .clk_i, .rst_ni, .clr_i(sync_hit), .en_i(keep_stb && !first_q), .bit_i(dbit), .crc_o(crc5)
  );

  usb_rx_crc #(.W(CRC16_W), .POLY(CRC16_POLY)) u_crc16 (
    .clk_i, .rst_ni, .clr_i(sync_hit), .en_i(keep_stb && !first_q), .bit_i(dbit), .crc_o(crc16)
  );

  always_comb begin
    crc_bad = 1'b0;
    if (!first_q) begin
      unique case (pid_kind_e'(pid_o[1:0]))
        PK_TOKEN: crc_bad = (crc5  != RES5_W[CRC5_W-1:0]);
        PK_DATA:  crc_bad = (crc16 != RES16_W);
        default:  crc_bad = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_pkt      <= 1'b0;
      zcnt_q      <= '0;
      sh_q        <= '0;
      bcnt_q      <= '0;
      first_q     <= 1'b0;
      pid_good_q  <= 1'b0;
      stuff_acc_q <= 1'b0;
      byte_o      <= '0;
      byte_vld_o  <= 1'b0;
      byte_sop_o  <= 1'b0;
      pid_o       <= '0;
      pkt_end_o   <= 1'b0;
      pid_err_o   <= 1'b0;
      crc_err_o   <= 1'b0;
      stuff_err_o <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      byte_sop_o <= 1'b0;
      pkt_end_o  <= 1'b0;
      if (!in_pkt) begin
        if (eop_i) zcnt_q <= '0;
        else if (bit_vld_i) begin
          if (dbit) begin
            zcnt_q <= '0;
            if (sync_hit) begin
              in_pkt      <= 1'b1;
              bcnt_q      <= '0;
              first_q     <= 1'b1;
              stuff_acc_q <= 1'b0;
            end
          end else if (zcnt_q != ZW'(SYNC_ZEROS)) begin
            zcnt_q <= zcnt_q + ZW'(1);
          end
        end
      end else if (eop_i) begin
        in_pkt      <= 1'b0;
        zcnt_q      <= '0;
        pkt_end_o   <= 1'b1;
        frame_err_o <= (bcnt_q != 3'd0) || first_q;
        pid_err_o   <= first_q || !pid_good_q;
        crc_err_o   <= crc_bad;
        stuff_err_o <= stuff_acc_q;
      end else if (bit_vld_i) begin
        if (stuff_hit) stuff_acc_q <= 1'b1;
        if (keep) begin
          sh_q   <= new_byte;
          bcnt_q <= bcnt_q + 3'd1;
          if (bcnt_q == 3'd7) begin
            byte_o     <= new_byte;
            byte_vld_o <= 1'b1;
            byte_sop_o <= first_q;
            if (first_q) begin
              pid_o      <= new_byte[3:0];
              pid_good_q <= (new_byte[7:4] == ~new_byte[3:0]);
              first_q    <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/usb_rx_engine_chk.sv
module usb_rx_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_vld_i,
  input logic       eop_i,
  input logic       in_pkt,
  input logic       byte_vld_o,
  input logic       byte_sop_o,
  input logic [3:0] pid_o,
  input logic       pkt_end_o,
  input logic       crc_err_o,
  input logic       frame_err_o
);
  AST_BYTE_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(bit_vld_i)); // R5

  AST_SOP_HAS_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_sop_o |-> byte_vld_o); // R5

  AST_END_AFTER_EOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |-> $past(eop_i)); // R11

  AST_NO_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_i && !in_pkt) |=> !pkt_end_o); // R2

  AST_CRC_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_end_o |-> $stable(crc_err_o)); // R11

  AST_FRAME_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_end_o |-> $stable(frame_err_o)); // R10

  AST_PID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_sop_o |-> $stable(pid_o)); // R6
endmodule

bind usb_rx_engine usb_rx_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_vld_i(bit_vld_i), .eop_i(eop_i), .in_pkt(in_pkt),
  .byte_vld_o(byte_vld_o), .byte_sop_o(byte_sop_o), .pid_o(pid_o), .pkt_end_o(pkt_end_o),
  .crc_err_o(crc_err_o), .frame_err_o(frame_err_o)
);

// File: tb/tb_usb_rx_engine.sv
`timescale 1ns/1ps
module tb_usb_rx_engine;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_vld_i = 1'b0, line_i = 1'b1, eop_i = 1'b0;
  logic [7:0] byte_o;
  logic byte_vld_o, byte_sop_o, pkt_end_o, pid_err_o, crc_err_o, stuff_err_o, frame_err_o;
  logic [3:0] pid_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  usb_rx_engine dut (
    .clk_i(clk), .rst_ni, .bit_vld_i, .line_i, .eop_i, .byte_o, .byte_vld_o, .byte_sop_o,
    .pid_o, .pkt_end_o, .pid_err_o, .crc_err_o, .stuff_err_o, .frame_err_o
  );

  logic       lvl = 1'b1;
  int         ones = 0;
  int         per = 4;
  logic       pkt_bits[$];
  logic [7:0] rx_q[$];
  int         sop_cnt = 0, end_cnt = 0, first_sop_idx = -1;

  always @(negedge clk) if (rst_ni) begin
    if (byte_vld_o) begin
      if (byte_sop_o) begin sop_cnt++; first_sop_idx = rx_q.size(); end
      rx_q.push_back(byte_o);
    end
    if (pkt_end_o) end_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic raw_bit(input logic b);
    lvl = b ? lvl : ~lvl;
    @(negedge clk); line_i = lvl; bit_vld_i = 1'b1;
    @(negedge clk); bit_vld_i = 1'b0;
    // line wiggles while strobe is low must be ignored (R12)
    line_i = ~lvl;
    repeat (per - 1) @(negedge clk);
    line_i = lvl;
  endtask

  task automatic data_bit(input logic b);
    raw_bit(b);
    ones = b ? ones + 1 : 0;
    if (ones == 6) begin raw_bit(1'b0); ones = 0; end
  endtask

  task automatic send_sync();
    repeat (7) raw_bit(1'b0);
    raw_bit(1'b1);
    ones = 1;
  endtask

  task automatic send_eop();
    @(negedge clk); eop_i = 1'b1;
    @(negedge clk); eop_i = 1'b0;
    lvl = 1'b1; line_i = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic add_byte(input logic [7:0] b, input int n);
    for (int j = 0; j < n; j++) pkt_bits.push_back(b[j]);
  endtask

  task automatic add_crc(input int w, input logic [15:0] poly);
    logic [15:0] c, mask;
    logic fb;
    mask = (16'h1 << w) - 16'h1;
    c = mask;
    for (int i = 8; i < pkt_bits.size(); i++) begin
      fb = c[w-1] ^ pkt_bits[i];
      c = ((c << 1) ^ (fb ? poly : 16'h0)) & mask;
    end
    for (int k = w - 1; k >= 0; k--) pkt_bits.push_back(~c[k]);
  endtask

  task automatic start_pkt();
    pkt_bits.delete(); rx_q.delete();
    sop_cnt = 0; end_cnt = 0; first_sop_idx = -1;
  endtask

  task automatic transmit();
    send_sync();
    foreach (pkt_bits[i]) data_bit(pkt_bits[i]);
    send_eop();
  endtask

  task automatic check_bytes(input string req);
    int n;
    logic [7:0] e;
    n = pkt_bits.size() / 8;
    chk(rx_q.size() == n, req, rx_q.size(), n);
    for (int i = 0; i < n && i < rx_q.size(); i++) begin
      e = '0;
      for (int j = 0; j < 8; j++) e[j] = pkt_bits[8*i + j];
      chk(rx_q[i] == e, req, rx_q[i], e);
    end
    chk(sop_cnt == (n > 0 ? 1 : 0) && first_sop_idx == (n > 0 ? 0 : -1), {req, " sop"}, sop_cnt, 1);
    chk(end_cnt == 1, {req, " end"}, end_cnt, 1);
  endtask

  task automatic t_reset();
    chk(byte_vld_o == 0 && pkt_end_o == 0 && byte_sop_o == 0, "R11 reset pulses", byte_vld_o, 0);
    chk({pid_err_o, crc_err_o, stuff_err_o, frame_err_o} == 4'b0, "R11 reset flags",
        {pid_err_o, crc_err_o, stuff_err_o, frame_err_o}, 0);
    chk(pid_o == 4'h0, "R6 reset pid", pid_o, 0);
  endtask

  task automatic t_token(input int p, input string req);
    per = p;
    start_pkt();
    add_byte(8'hE1, 8);
    add_byte(8'h3A, 8); add_byte(8'h05, 3);
    add_crc(5, 16'h0005);
    transmit();
    check_bytes(req);
    chk(crc_err_o == 0, "R7 token crc ok", crc_err_o, 0);
    chk(pid_err_o == 0 && pid_o == 4'h1, "R6 token pid", pid_o, 1);
    chk(frame_err_o == 0 && stuff_err_o == 0, req, {frame_err_o, stuff_err_o}, 0);
  endtask

  task automatic t_data_stuffed();
    per = 32;
    start_pkt();
    add_byte(8'hC3, 8);
    add_byte(8'hFF, 8); add_byte(8'hFF, 8); add_byte(8'h7E, 8); add_byte(8'h01, 8);
    add_crc(16, 16'h8005);
    transmit();
    check_bytes("R3 stuffed data");
    chk(crc_err_o == 0, "R8 data crc ok", crc_err_o, 0);
    chk(stuff_err_o == 0, "R4 no stuff err", stuff_err_o, 0);
    chk(pid_o == 4'h3 && pid_err_o == 0, "R6 data pid", pid_o, 3);
  endtask

  task automatic t_data_bad_crc();
    per = 4;
    start_pkt();
    add_byte(8'h4B, 8);
    add_byte(8'h12, 8); add_byte(8'h34, 8);
    add_crc(16, 16'h8005);
    pkt_bits[13] = ~pkt_bits[13];
    transmit();
    check_bytes("R8 corrupted data");
    chk(crc_err_o == 1, "R8 crc err", crc_err_o, 1);
  endtask

  task automatic t_token_bad_crc();
    per = 4;
    start_pkt();
    add_byte(8'h69, 8);
    add_byte(8'h81, 8); add_byte(8'h02, 3);
    add_crc(5, 16'h0005);
    pkt_bits[22] = ~pkt_bits[22];
    transmit();
    chk(crc_err_o == 1, "R7 token crc err", crc_err_o, 1);
  endtask

  task automatic t_handshake();
    per = 4;
    start_pkt();
    add_byte(8'hD2, 8);
    transmit();
    check_bytes("R9 handshake");
    chk(crc_err_o == 0 && pid_err_o == 0, "R9 no crc check", crc_err_o, 0);
    chk(pid_o == 4'h2, "R6 handshake pid", pid_o, 2);
  endtask

  task automatic t_bad_pid();
    per = 4;
    start_pkt();
    add_byte(8'h12, 8);
    transmit();
    chk(pid_err_o == 1, "R6 pid err", pid_err_o, 1);
    chk(pid_o == 4'h2, "R6 bad pid value", pid_o, 2);
  endtask

  task automatic t_frame();
    per = 4;
    start_pkt();
    add_byte(8'hE1, 8); add_byte(8'h3A, 8); add_byte(8'h05, 3);
    add_crc(5, 16'h0005);
    add_byte(8'h05, 3);
    transmit();
    chk(rx_q.size() == 3, "R10 frame bytes", rx_q.size(), 3);
    chk(frame_err_o == 1, "R10 frame err", frame_err_o, 1);
    start_pkt();
    send_sync(); send_eop();
    chk(end_cnt == 1 && frame_err_o == 1 && pid_err_o == 1, "R10 empty packet",
        {frame_err_o, pid_err_o}, 3);
  endtask

  task automatic t_stuff_err();
    per = 4;
    start_pkt();
    send_sync();
    for (int j = 0; j < 8; j++) data_bit(pkt_bit_of(8'hD2, j));
    repeat (7) raw_bit(1'b1);
    raw_bit(1'b0);
    send_eop();
    chk(stuff_err_o == 1, "R4 stuff err", stuff_err_o, 1);
    chk(end_cnt == 1, "R4 end", end_cnt, 1);
  endtask

  function automatic logic pkt_bit_of(input logic [7:0] b, input int j);
    return b[j];
  endfunction

  task automatic t_idle();
    per = 4;
    start_pkt();
    send_eop();
    chk(end_cnt == 0, "R2 eop idle", end_cnt, 0);
    // noise with short zero runs, then a real packet
    raw_bit(1'b0); raw_bit(1'b0); raw_bit(1'b1); raw_bit(1'b0); raw_bit(1'b1); raw_bit(1'b1);
    chk(rx_q.size() == 0, "R2 noise no bytes", rx_q.size(), 0);
    add_byte(8'hD2, 8);
    transmit();
    check_bytes("R2 after noise");
    chk(pid_o == 4'h2, "R1 nrzi pid", pid_o, 2);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_token(4, "R5 token full rate");
    t_token(32, "R12 token low rate");
    t_data_stuffed();
    t_data_bad_crc();
    t_token_bad_crc();
    t_handshake();
    t_bad_pid();
    t_frame();
    t_stuff_err();
    t_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule